// File: doc/BRIEF.md
# Parallel Host Register Bus Slave

This block lets an external host processor read and write a small bank of 8-bit registers over an asynchronous parallel bus. The bus has an active-low chip select, separate active-low read and write strobes, an address latch enable and an active-low ready handshake. The 9-bit address follows the address input while the latch enable is high and is frozen when the enable falls, so a later change on the address pins no longer matters for that access.

All bus inputs are brought into the internal clock domain through two-flop synchronizers. Strobe falling edges are found on the internal clock. Each access ends with ready driven low, and the host must wait for it before it releases its strobe. The bidirectional data bus is split into a data input, a data output and an output enable. Every accepted write to a mapped register sends a one-cycle pulse, with the register index and value, to downstream logic.

Top module: `pbusSlave`

## Requirements
- R1: After reset, ready is high, the output enable is low, the data output is 0x00, the write pulse is low and all 16 registers hold 0x00.
- R2: While chip select is high, the read and write strobes cause no access: ready stays high, the output enable stays low and no register changes.
- R3: While the latch enable is high, the internal address follows the address input. Its high-to-low transition freezes the address, and later address input changes do not affect the access.
- R4: A read (read strobe falling while chip select is low) loads the addressed register, and the data output carries it while the output enable is high. Whenever the output enable is low, the data output is 0x00.
- R5: Ready goes low once the read data is loaded or the write is stored. It returns high when the active strobe is released or chip select goes high.
- R6: A write (write strobe falling while chip select is low and the read strobe is high) stores the data input in the addressed register. It also gives a one-cycle write pulse carrying the 4-bit register index (address bits 3:0) and the value.
- R7: Only addresses 0x000 to 0x00F are mapped. A read of any other address returns 0x00. A write to one is discarded with no pulse, but ready is still given.
- R8: The output enable is high only while the synchronized chip select and read strobe are both low.
- R9: Ready falls on the third clock edge after a strobe falls. It rises on the second clock edge after the strobe rises.
- R10: A strobe held low performs exactly one access. A write strobe that falls while the read strobe is low is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Active-low chip select (asynchronous) |
| aleIn | input | 1 | Address latch enable, high = transparent |
| addrIn | input | 9 | Address bus |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| dataIn | input | 8 | Data bus, host to block |
| dataOut | output | 8 | Data bus, block to host |
| dataOe | output | 1 | Drive enable for the data bus |
| rdyN | output | 1 | Active-low ready |
| wrPulse | output | 1 | One-cycle pulse on a stored write |
| wrIdx | output | 4 | Index of the written register |
| wrData | output | 8 | Value written |

## Verification
The bench targets address capture on the latch-enable fall, including an address that changes during the transparent phase and one that changes after the fall. A design that sampled the address at the strobe would return the wrong register. It drives strobes with chip select high, holds a write strobe low for many cycles, and lets a write strobe fall while a read is still held. A level-triggered or unguarded design would then show extra write pulses, drive the bus, or overwrite a register. Accesses to 0x010 and 0x1FF check that unmapped addresses neither alias onto register 0 nor withhold ready. Exact ready latencies are counted so that an extra or missing synchronizer stage shows up.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_RD_ACK,
    BUS_WR_ACK
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRd;
    logic doWrite;
  } ctlStrobes_t;
endpackage

// File: rtl/pbusSync.sv
module pbusSync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST;
      q      <= RST;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pbusCtrl.sv
module pbusCtrl
  import pbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csS,
  input  logic        rdS,
  input  logic        wrS,
  output ctlStrobes_t ctl,
  output logic        rdyN,
  output logic        dataOe
);
  logic      rdD, wrD;
  logic      rdFall, wrFall;
  busState_t st, stNext;

  assign rdFall = !rdS && rdD;
  assign wrFall = !wrS && wrD && rdS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdD <= 1'b1;
      wrD <= 1'b1;
      st  <= BUS_IDLE;
    end else begin
      rdD <= rdS;
      wrD <= wrS;
      st  <= stNext;
    end
  end

  always_comb begin
    stNext = st;
    ctl    = '0;
    unique case (st)
      BUS_IDLE: begin
        if (!csS) begin
          if (rdFall) begin
            ctl.loadRd = 1'b1;
            stNext     = BUS_RD_ACK;
          end else if (wrFall) begin
            ctl.doWrite = 1'b1;
            stNext      = BUS_WR_ACK;
          end
        end
      end
      BUS_RD_ACK: if (rdS || csS) stNext = BUS_IDLE;
      BUS_WR_ACK: if (wrS || csS) stNext = BUS_IDLE;
      default:    stNext = BUS_IDLE;
    endcase
  end

  assign rdyN   = !(!csS && ((st == BUS_RD_ACK && !rdS) ||
                             (st == BUS_WR_ACK && !wrS)));
  assign dataOe = !csS && !rdS;

  // R5
  rdy_after_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyN) |-> $past(ctl.loadRd || ctl.doWrite));

  // R10
  single_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadRd || ctl.doWrite) |=> !(ctl.loadRd || ctl.doWrite));
endmodule

// File: rtl/pbusData.sv
module pbusData
  import pbus_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aleS,
  input  logic [ADDR_W-1:0] addrS,
  input  logic [DATA_W-1:0] dataS,
  input  ctlStrobes_t       ctl,
  input  logic              dataOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              wrPulse,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrData
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] regFile [DEPTH];
  logic [DATA_W-1:0] readBuf;
  logic [DATA_W-1:0] readMux;
  logic              mapped;
  logic [IDX_W-1:0]  idx;

  assign mapped = addrReg <= LAST_ADDR;
  assign idx    = addrReg[IDX_W-1:0];

  // transparent while enable high, frozen after its fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     addrReg <= '0;
    else if (aleS) addrReg <= addrS;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[g] <= '0;
      else if (ctl.doWrite && mapped && idx == IDX_W'(g))
        regFile[g] <= dataS;
    end
  end

  assign readMux = mapped ? regFile[idx] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readBuf <= '0;
      wrPulse <= 1'b0;
      wrIdx   <= '0;
      wrData  <= '0;
    end else begin
      if (ctl.loadRd) readBuf <= readMux;
      wrPulse <= ctl.doWrite && mapped;
      if (ctl.doWrite) begin
        wrIdx  <= idx;
        wrData <= dataS;
      end
    end
  end

  assign dataOut = dataOe ? readBuf : '0;

  // R6
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);

  // R6
  wr_stored_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> regFile[wrIdx] == wrData);

  // R4
  rd_buf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadRd |=> $stable(readBuf));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !aleS |=> $stable(addrReg));
endmodule

// File: rtl/pbusSlave.sv
module pbusSlave
  import pbus_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              aleIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              rdyN,
  output logic              wrPulse,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrData
);
  localparam int PAY_W = ADDR_W + DATA_W;

  logic [3:0]        ctlS;
  logic [PAY_W-1:0]  payS;
  logic              csS, aleS, rdS, wrS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;
  ctlStrobes_t       ctl;

  pbusSync #(.W(4), .RST(4'b1011)) u_ctlSync (
    .clk(clk), .rstN(rstN), .d({csN, aleIn, rdN, wrN}), .q(ctlS)
  );

  pbusSync #(.W(PAY_W), .RST('0)) u_paySync (
    .clk(clk), .rstN(rstN), .d({addrIn, dataIn}), .q(payS)
  );

  assign {csS, aleS, rdS, wrS} = ctlS;
  assign {addrS, dataS}        = payS;

  pbusCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csS(csS), .rdS(rdS), .wrS(wrS),
    .ctl(ctl), .rdyN(rdyN), .dataOe(dataOe)
  );

  pbusData #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rstN(rstN), .aleS(aleS), .addrS(addrS), .dataS(dataS),
    .ctl(ctl), .dataOe(dataOe), .dataOut(dataOut),
    .wrPulse(wrPulse), .wrIdx(wrIdx), .wrData(wrData)
  );
endmodule

// File: tb/pbusSlave_tb.sv
module pbusSlave_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, aleIn = 1'b0, rdN = 1'b1, wrN = 1'b1;
  logic [8:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut, wrData;
  logic       dataOe, rdyN, wrPulse;
  logic [3:0] wrIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbusSlave u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .aleIn(aleIn), .addrIn(addrIn),
    .rdN(rdN), .wrN(wrN), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .rdyN(rdyN), .wrPulse(wrPulse), .wrIdx(wrIdx),
    .wrData(wrData)
  );

  int checks = 0, errors = 0, cycles = 0, pulseCnt = 0;
  bit finished = 0;
  int shadow [16];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mCs[3], mRd[3], mWr[3], mAle[2], mA[2], mD[2];
  int mAddrL, mMode, mBuf, mPulse, mIdx, mWdat;
  int mMem [16];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin mCs[i] = 1; mRd[i] = 1; mWr[i] = 1; end
      for (int i = 0; i < 2; i++) begin mAle[i] = 0; mA[i] = 0; mD[i] = 0; end
      for (int i = 0; i < 16; i++) mMem[i] = 0;
      mAddrL = 0; mMode = 0; mBuf = 0; mPulse = 0; mIdx = 0; mWdat = 0;
    end else begin
      mPulse = 0;
      if (mMode == 0) begin
        if (mCs[1] == 0 && mRd[2] == 1 && mRd[1] == 0) begin
          mBuf  = (mAddrL < 16) ? mMem[mAddrL] : 0;
          mMode = 1;
        end else if (mCs[1] == 0 && mWr[2] == 1 && mWr[1] == 0 && mRd[1] == 1) begin
          if (mAddrL < 16) begin
            mMem[mAddrL] = mD[1];
            mPulse = 1;
          end
          mIdx  = mAddrL % 16;
          mWdat = mD[1];
          mMode = 2;
        end
      end else if (mMode == 1) begin
        if (mRd[1] == 1 || mCs[1] == 1) mMode = 0;
      end else begin
        if (mWr[1] == 1 || mCs[1] == 1) mMode = 0;
      end
      if (mAle[1] == 1) mAddrL = mA[1];
      mCs[2] = mCs[1]; mCs[1] = mCs[0]; mCs[0] = int'(csN);
      mRd[2] = mRd[1]; mRd[1] = mRd[0]; mRd[0] = int'(rdN);
      mWr[2] = mWr[1]; mWr[1] = mWr[0]; mWr[0] = int'(wrN);
      mAle[1] = mAle[0]; mAle[0] = int'(aleIn);
      mA[1] = mA[0]; mA[0] = int'(addrIn);
      mD[1] = mD[0]; mD[0] = int'(dataIn);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int eOe, eOut, eRdy;
      eOe  = (mCs[1] == 0 && mRd[1] == 0) ? 1 : 0;
      eOut = eOe ? mBuf : 0;
      eRdy = (mCs[1] == 0 && ((mMode == 1 && mRd[1] == 0) ||
                              (mMode == 2 && mWr[1] == 0))) ? 0 : 1;
      chk(int'(rdyN) == eRdy, "R5", "model rdyN", int'(rdyN), eRdy);
      chk(int'(dataOe) == eOe, "R8", "model dataOe", int'(dataOe), eOe);
      chk(int'(dataOut) == eOut, "R4", "model dataOut", int'(dataOut), eOut);
      chk(int'(wrPulse) == mPulse, "R6", "model wrPulse", int'(wrPulse), mPulse);
      if (mPulse == 1) begin
        chk(int'(wrIdx) == mIdx, "R6", "model wrIdx", int'(wrIdx), mIdx);
        chk(int'(wrData) == mWdat, "R6", "model wrData", int'(wrData), mWdat);
      end
      if (wrPulse) pulseCnt++;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic latchAddr(int a);
    @(negedge clk); csN = 1'b0; addrIn = 9'(a); aleIn = 1'b1;
    waitN(3); aleIn = 1'b0;
    waitN(3);
  endtask

  task automatic waitRdy(logic lvl, output int n);
    n = 0;
    while (rdyN !== lvl && n < 40) begin @(negedge clk); n++; end
  endtask

  task automatic strobeRead(output int d, output int latF, output int latR);
    @(negedge clk); rdN = 1'b0;
    waitRdy(1'b0, latF);
    d = int'(dataOut);
    chk(dataOe == 1'b1, "R4", "dataOe at ready", int'(dataOe), 1);
    rdN = 1'b1;
    waitRdy(1'b1, latR);
    chk(dataOe == 1'b0, "R8", "dataOe after release", int'(dataOe), 0);
    chk(dataOut == 8'h00, "R4", "dataOut after release", int'(dataOut), 0);
    waitN(2);
  endtask

  task automatic strobeWrite(int d, int hold, output int latF, output int latR);
    @(negedge clk); dataIn = 8'(d);
    waitN(3); wrN = 1'b0;
    waitRdy(1'b0, latF);
    waitN(hold);
    wrN = 1'b1;
    waitRdy(1'b1, latR);
    waitN(2);
  endtask

  task automatic hostWrite(int a, int d);
    int lf, lr, p0;
    p0 = pulseCnt;
    latchAddr(a);
    strobeWrite(d, 0, lf, lr);
    if (a < 16) begin
      shadow[a] = d;
      chk(pulseCnt - p0 == 1, "R6", "pulse count", pulseCnt - p0, 1);
    end else begin
      chk(pulseCnt - p0 == 0, "R7", "pulse on unmapped", pulseCnt - p0, 0);
    end
    chk(lf == 3, "R9", "write ready fall latency", lf, 3);
    chk(lr == 2, "R9", "write ready rise latency", lr, 2);
  endtask

  task automatic hostRead(int a, int exp, string req);
    int d, lf, lr;
    latchAddr(a);
    strobeRead(d, lf, lr);
    chk(d == exp, req, "read data", d, exp);
    chk(lf == 3, "R9", "read ready fall latency", lf, 3);
    chk(lr == 2, "R9", "read ready rise latency", lr, 2);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int d, lf, lr, p0;
    for (int i = 0; i < 16; i++) shadow[i] = 0;
    waitN(4);
    // R1 reset state
    chk(rdyN == 1'b1, "R1", "reset rdyN", int'(rdyN), 1);
    chk(dataOe == 1'b0, "R1", "reset dataOe", int'(dataOe), 0);
    chk(dataOut == 8'h00, "R1", "reset dataOut", int'(dataOut), 0);
    chk(wrPulse == 1'b0, "R1", "reset wrPulse", int'(wrPulse), 0);
    rstN = 1'b1;
    waitN(3);
    hostRead(7, 0, "R1");

    // R6 write every register, R4 read back
    for (int i = 0; i < 16; i++) hostWrite(i, (i * 37 + 5) & 8'hFF);
    for (int i = 15; i >= 0; i--) hostRead(i, shadow[i], "R4");

    // R7 unmapped addresses
    hostWrite(9'h1FF, 8'hAA);
    hostWrite(9'h010, 8'h55);
    hostRead(9'h1FF, 0, "R7");
    hostRead(9'h010, 0, "R7");
    hostRead(0, shadow[0], "R7");

    // R3 address follows input while enable high
    @(negedge clk); csN = 1'b0; addrIn = 9'd2; aleIn = 1'b1;
    waitN(3); addrIn = 9'd11;
    waitN(3); aleIn = 1'b0;
    waitN(3);
    strobeRead(d, lf, lr);
    chk(d == shadow[11], "R3", "transparent address", d, shadow[11]);
    // R3 change after enable fall ignored
    @(negedge clk); addrIn = 9'd4; aleIn = 1'b1;
    waitN(3); aleIn = 1'b0;
    waitN(1); addrIn = 9'd9;
    waitN(3);
    strobeRead(d, lf, lr);
    chk(d == shadow[4], "R3", "latched address", d, shadow[4]);
    addrIn = 9'd9;

    // R2 strobes ignored with chip select high
    latchAddr(3);
    @(negedge clk); csN = 1'b1; dataIn = 8'h5A;
    p0 = pulseCnt;
    waitN(3); wrN = 1'b0;
    waitN(8);
    chk(rdyN == 1'b1, "R2", "rdyN with cs high (write)", int'(rdyN), 1);
    wrN = 1'b1; waitN(3); rdN = 1'b0;
    waitN(8);
    chk(rdyN == 1'b1, "R2", "rdyN with cs high (read)", int'(rdyN), 1);
    chk(dataOe == 1'b0, "R2", "dataOe with cs high", int'(dataOe), 0);
    rdN = 1'b1; waitN(3);
    chk(pulseCnt == p0, "R2", "pulse with cs high", pulseCnt - p0, 0);
    hostRead(3, shadow[3], "R2");

    // R10 write strobe held low: one access only
    latchAddr(6);
    p0 = pulseCnt;
    strobeWrite(8'hC3, 20, lf, lr);
    shadow[6] = 8'hC3;
    chk(pulseCnt - p0 == 1, "R10", "pulses with held strobe", pulseCnt - p0, 1);
    hostRead(6, 8'hC3, "R10");

    // R10 write strobe falling while read still held
    latchAddr(8);
    @(negedge clk); dataIn = 8'h3C; rdN = 1'b0;
    waitRdy(1'b0, lf);
    p0 = pulseCnt;
    wrN = 1'b0; waitN(8);
    chk(pulseCnt == p0, "R10", "write during read", pulseCnt - p0, 0);
    chk(dataOe == 1'b1, "R8", "oe held during read", int'(dataOe), 1);
    wrN = 1'b1; rdN = 1'b1; waitN(4);
    hostRead(8, shadow[8], "R10");

    // R5 chip select rising ends the handshake
    latchAddr(1);
    @(negedge clk); rdN = 1'b0;
    waitRdy(1'b0, lf);
    csN = 1'b1; waitN(2);
    chk(rdyN == 1'b1, "R5", "rdyN after cs rise", int'(rdyN), 1);
    rdN = 1'b1; waitN(4);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule